// File: doc/BRIEF.md
# Software Inter-Hart Interrupt Controller

This block lets software on any hart raise a machine software interrupt on any hart, itself included. Each hart owns exactly one interrupt source, numbered one above its hart index. Source number 0 is reserved and never holds state. A hart is signalled by setting that source's pending bit through the register bus. The target hart picks up the interrupt with a claim read and returns it with a complete write.

Every source has a priority register, a pending bit and one enable bit per hart. For each hart the controller selects the best source that is pending, enabled for that hart, not already claimed, and above the fixed zero threshold. It drives that hart's interrupt line while such a source exists. The register port is a single-cycle bus with byte addresses on word boundaries. Read data is returned combinationally in the cycle the read is presented. Writes and read side effects take place at the next rising clock edge.

Top module: `swi_ctrl`

## Requirements
- R1: Source 0 does not exist: its pending bit (bit 0 of the pending word at 0x1000), its enable bits (bit 0 of each hart's first enable word) and its priority word (0x0) always read 0, and writes to them change nothing.
- R2: The pending array starts at 0x1000. Word w at 0x1000+4w covers sources 32w to 32w+31, and the bit position is the source number mod 32. Writing 1 sets a bit and writing 0 leaves it unchanged.
- R3: The priority of source s is a PRIO_W-bit value at byte address 4s. It reads back as written, zero-extended.
- R4: The enable bits of hart h are at 0x2000+0x80h+4w, with source s in word s/32 at bit s mod 32. A write replaces the whole word.
- R5: irq_o[h] is 1 exactly when some source is pending, enabled for hart h, not claimed, and has a priority above 0.
- R6: A read of hart h's claim word at 0x200000+0x1000h+4 returns the eligible source with the highest priority, taking the lowest number on a tie. The same read clears that source's pending bit and marks it claimed.
- R7: A claim read with no eligible source returns 0 and changes no state.
- R8: A claimed source is not presented again, even if it is set pending again, until a complete write of its number arrives.
- R9: A complete write, which writes a source number to the claim word, releases only a source that is currently claimed. Any other value is ignored.
- R10: Reset clears all pending, claimed, enable and priority state, and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; needed for claim side effects |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | NHARTS | Machine software interrupt line per hart |

## Verification
Arbitration is driven with a higher-priority source beating a lower one, with equal priorities where the lowest number must win, and with a zero-priority source that must stay invisible. Together these separate a priority comparator from a plain index scan. Pending writes of 1s, 0s and bit 0 show that set-only behaviour and the reserved source are decoded apart. Re-pending a claimed source and issuing a complete write with the wrong number separate a correct claim gate from one that presents or releases too early. A source in the second pending word, seen by the highest hart, exercises the word split in the address decode.

// File: rtl/swi_pkg.sv
package swi_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_EN,
        RG_CLAIM
    } region_e;

    typedef struct packed {
        region_e     region;
        logic [15:0] idx;   // source number (PRIO) or hart index (EN, CLAIM)
        logic [15:0] word;  // word index inside a bit array (PEND, EN)
    } dec_t;

    localparam int unsigned PRIO_BASE  = 32'h0000_0000;
    localparam int unsigned PEND_BASE  = 32'h0000_1000;
    localparam int unsigned EN_BASE    = 32'h0000_2000;
    localparam int unsigned EN_STRIDE  = 32'h0000_0080;
    localparam int unsigned CTX_BASE   = 32'h0020_0000;
    localparam int unsigned CTX_STRIDE = 32'h0000_1000;
    localparam int unsigned CLAIM_OFS  = 32'h0000_0004;

endpackage

// File: rtl/swi_decode.sv
module swi_decode
    import swi_pkg::*;
#(
    parameter int unsigned NHARTS = 32,
    parameter int unsigned NSRC   = NHARTS + 1,
    parameter int unsigned NWORDS = (NSRC + 31) / 32,
    parameter int unsigned ADDR_W = 22
) (
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);

    localparam int unsigned EN_END  = EN_BASE + EN_STRIDE * NHARTS;
    localparam int unsigned CTX_END = CTX_BASE + CTX_STRIDE * NHARTS;

    logic [31:0] a;
    logic [31:0] rel;

    always_comb begin
        a     = 32'(addr_i);
        rel   = '0;
        dec_o = '{region: RG_NONE, idx: '0, word: '0};
        if (a[1:0] == 2'b00) begin
            if (a < PEND_BASE) begin
                if ((a >> 2) < NSRC) begin
                    dec_o.region = RG_PRIO;
                    dec_o.idx    = 16'(a >> 2);
                end
            end else if (a < PEND_BASE + 32'h80) begin
                if (((a - PEND_BASE) >> 2) < NWORDS) begin
                    dec_o.region = RG_PEND;
                    dec_o.word   = 16'((a - PEND_BASE) >> 2);
                end
            end else if (a >= EN_BASE && a < EN_END) begin
                rel = a - EN_BASE;
                if (((rel % EN_STRIDE) >> 2) < NWORDS) begin
                    dec_o.region = RG_EN;
                    dec_o.idx    = 16'(rel / EN_STRIDE);
                    dec_o.word   = 16'((rel % EN_STRIDE) >> 2);
                end
            end else if (a >= CTX_BASE && a < CTX_END) begin
                rel = a - CTX_BASE;
                if ((rel % CTX_STRIDE) == CLAIM_OFS) begin
                    dec_o.region = RG_CLAIM;
                    dec_o.idx    = 16'(rel / CTX_STRIDE);
                end
            end
        end
    end

endmodule

// File: rtl/swi_arbiter.sv
module swi_arbiter #(
    parameter int unsigned NSRC   = 33,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned SRC_W  = $clog2(NSRC)
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [NSRC-1:0]              cand_i,
    input  logic [NSRC-1:0][PRIO_W-1:0]  prio_i,
    output logic [SRC_W-1:0]             id_o,
    output logic                         valid_o
);

    logic [PRIO_W-1:0] best_p;

    // Ascending scan with a strict compare keeps the lowest number on ties;
    // starting from 0 enforces the zero threshold.
    always_comb begin
        best_p  = '0;
        id_o    = '0;
        valid_o = 1'b0;
        for (int s = 1; s < int'(NSRC); s++) begin
            if (cand_i[s] && prio_i[s] > best_p) begin
                best_p  = prio_i[s];
                id_o    = SRC_W'(s);
                valid_o = 1'b1;
            end
        end
    end

    // R5: a presented source is a candidate with nonzero priority
    assert_winner_eligible_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (cand_i[id_o] && prio_i[id_o] != '0));

    // R5: no interrupt while some candidate has a priority above zero
    assert_no_lost_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> (best_p == '0));

endmodule

// File: rtl/swi_ctrl.sv
module swi_ctrl
    import swi_pkg::*;
#(
    parameter int unsigned NHARTS = 32,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned ADDR_W = 22
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic [NHARTS-1:0] irq_o
);

    localparam int unsigned NSRC   = NHARTS + 1;
    localparam int unsigned NWORDS = (NSRC + 31) / 32;
    localparam int unsigned SRC_W  = $clog2(NSRC);
    localparam int unsigned HART_W = (NHARTS > 1) ? $clog2(NHARTS) : 1;

    typedef struct packed {
        logic [NSRC-1:0]              pend;
        logic [NSRC-1:0]              busy;
        logic [NHARTS-1:0][NSRC-1:0]  en;
        logic [NSRC-1:0][PRIO_W-1:0]  prio;
    } state_t;

    state_t st_d, st_q;
    dec_t   dec;

    logic [NHARTS-1:0][SRC_W-1:0] win_id;
    logic [NHARTS-1:0]            win_valid;
    logic [HART_W-1:0]            hsel;
    logic [SRC_W-1:0]             claim_id;
    logic                         claim_valid;
    logic                         claim_rd;
    logic                         claim_wr;

    swi_decode #(
        .NHARTS(NHARTS),
        .NSRC  (NSRC),
        .NWORDS(NWORDS),
        .ADDR_W(ADDR_W)
    ) u_decode (
        .addr_i(addr_i),
        .dec_o (dec)
    );

    for (genvar h = 0; h < int'(NHARTS); h++) begin : g_hart
        logic [NSRC-1:0] cand;
        assign cand = st_q.pend & ~st_q.busy & st_q.en[h];

        swi_arbiter #(
            .NSRC  (NSRC),
            .PRIO_W(PRIO_W),
            .SRC_W (SRC_W)
        ) u_arb (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cand_i (cand),
            .prio_i (st_q.prio),
            .id_o   (win_id[h]),
            .valid_o(win_valid[h])
        );

        assign irq_o[h] = win_valid[h];

        // R8: a claimed source is never the presented winner
        assert_claimed_hidden_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            win_valid[h] |-> !st_q.busy[win_id[h]]);
    end

    assign hsel        = HART_W'(dec.idx);
    assign claim_id    = win_id[hsel];
    assign claim_valid = win_valid[hsel];
    assign claim_rd    = rd_en_i && dec.region == RG_CLAIM;
    assign claim_wr    = wr_en_i && dec.region == RG_CLAIM;

    always_comb begin
        int s;
        st_d    = st_q;
        rdata_o = '0;
        s       = 0;
        unique case (dec.region)
            RG_PRIO: begin
                rdata_o = 32'(st_q.prio[SRC_W'(dec.idx)]);
                if (wr_en_i && dec.idx != '0)
                    st_d.prio[SRC_W'(dec.idx)] = wdata_i[PRIO_W-1:0];
            end
            RG_PEND: begin
                for (int b = 0; b < 32; b++) begin
                    s = int'(dec.word) * 32 + b;
                    if (s < int'(NSRC)) begin
                        rdata_o[b] = st_q.pend[SRC_W'(s)];
                        if (wr_en_i && s != 0 && wdata_i[b])
                            st_d.pend[SRC_W'(s)] = 1'b1;
                    end
                end
            end
            RG_EN: begin
                for (int b = 0; b < 32; b++) begin
                    s = int'(dec.word) * 32 + b;
                    if (s < int'(NSRC)) begin
                        rdata_o[b] = st_q.en[hsel][SRC_W'(s)];
                        if (wr_en_i && s != 0)
                            st_d.en[hsel][SRC_W'(s)] = wdata_i[b];
                    end
                end
            end
            RG_CLAIM: begin
                if (rd_en_i) begin
                    rdata_o = 32'(claim_id);
                    if (claim_valid) begin
                        st_d.pend[claim_id] = 1'b0;
                        st_d.busy[claim_id] = 1'b1;
                    end
                end
                if (wr_en_i && wdata_i != '0 && wdata_i < NSRC
                    && st_q.busy[SRC_W'(wdata_i)])
                    st_d.busy[SRC_W'(wdata_i)] = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R1: the reserved source never reads back as pending
    assert_src0_never_pending_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && dec.region == RG_PEND && dec.word == '0) |-> !rdata_o[0]);

    // R6: a successful claim marks the returned source claimed and not pending
    assert_claim_takes_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (claim_rd && claim_valid && !claim_wr)
            |=> (st_q.busy[$past(claim_id)] && !st_q.pend[$past(claim_id)]));

    // R7: an empty claim leaves pending and claimed state alone
    assert_empty_claim_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (claim_rd && !claim_valid && !claim_wr)
            |=> ($stable(st_q.pend) && $stable(st_q.busy)));

    // R9: completing a number that is not claimed changes no claim state
    assert_bad_complete_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (claim_wr && !rd_en_i && (wdata_i >= NSRC || !st_q.busy[SRC_W'(wdata_i)]))
            |=> $stable(st_q.busy));

endmodule

// File: tb/swi_ctrl_tb.sv
`timescale 1ns/1ps
module swi_ctrl_tb_top;

    localparam int unsigned NHARTS = 32;
    localparam int unsigned ADDR_W = 22;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr = 1'b0;
    logic              rd = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NHARTS-1:0] irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    swi_ctrl #(.NHARTS(NHARTS), .PRIO_W(3), .ADDR_W(ADDR_W)) dut_i (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .addr_i (addr),
        .wr_en_i(wr),
        .rd_en_i(rd),
        .wdata_i(wdata),
        .rdata_o(rdata),
        .irq_o  (irq)
    );

    // vector: kind(0 write, 1 read check, 2 irq check), req, addr, value
    localparam int NV = 50;
    localparam logic [59:0] VEC [NV] = '{
        {2'd0, 4'd3,  22'h000004, 32'h2},        // prio src1 = 2
        {2'd1, 4'd3,  22'h000004, 32'h2},        // R3 readback
        {2'd0, 4'd3,  22'h000008, 32'h5},        // prio src2 = 5
        {2'd0, 4'd3,  22'h000080, 32'h1},        // prio src32 = 1
        {2'd0, 4'd1,  22'h000000, 32'h7},        // R1 write reserved prio
        {2'd1, 4'd1,  22'h000000, 32'h0},        // R1 reads 0
        {2'd0, 4'd4,  22'h002000, 32'h7},        // hart0 enables, bit0 dropped
        {2'd1, 4'd4,  22'h002000, 32'h6},        // R4 and R1
        {2'd0, 4'd4,  22'h002F84, 32'h1},        // hart31 word1 enables src32
        {2'd1, 4'd4,  22'h002F84, 32'h1},        // R4
        {2'd2, 4'd5,  22'h000000, 32'h0},        // R5 nothing pending
        {2'd0, 4'd2,  22'h001000, 32'h2},        // pend src1
        {2'd2, 4'd5,  22'h000000, 32'h1},        // R5 hart0 line up
        {2'd0, 4'd2,  22'h001000, 32'h0},        // R2 write zero
        {2'd1, 4'd2,  22'h001000, 32'h2},        // R2 unchanged
        {2'd0, 4'd2,  22'h001000, 32'h5},        // bit0 and src2
        {2'd1, 4'd1,  22'h001000, 32'h6},        // R1 bit0 ignored, R2 set
        {2'd1, 4'd6,  22'h200004, 32'h2},        // R6 higher prio wins
        {2'd1, 4'd6,  22'h001000, 32'h2},        // R6 src2 pending cleared
        {2'd2, 4'd5,  22'h000000, 32'h1},        // src1 still eligible
        {2'd0, 4'd8,  22'h001000, 32'h4},        // re-pend claimed src2
        {2'd1, 4'd8,  22'h200004, 32'h1},        // R8 src2 hidden
        {2'd2, 4'd8,  22'h000000, 32'h0},        // R8 line low
        {2'd1, 4'd7,  22'h200004, 32'h0},        // R7 empty claim
        {2'd1, 4'd7,  22'h001000, 32'h4},        // R7 pending intact
        {2'd0, 4'd9,  22'h200004, 32'h1},        // complete src1
        {2'd0, 4'd9,  22'h200004, 32'h3},        // wrong number
        {2'd2, 4'd9,  22'h000000, 32'h0},        // R9 src2 still held
        {2'd0, 4'd9,  22'h200004, 32'h2},        // complete src2
        {2'd2, 4'd8,  22'h000000, 32'h1},        // R8 src2 presented again
        {2'd1, 4'd6,  22'h200004, 32'h2},        // claim src2
        {2'd0, 4'd9,  22'h200004, 32'h2},        // complete src2
        {2'd0, 4'd2,  22'h001004, 32'h1},        // pend src32 in word1
        {2'd1, 4'd2,  22'h001004, 32'h1},        // R2 word1
        {2'd2, 4'd5,  22'h000000, 32'h8000_0000},// R5 hart31
        {2'd1, 4'd6,  22'h21F004, 32'h20},       // R6 hart31 claims 32
        {2'd2, 4'd6,  22'h000000, 32'h0},        // line drops
        {2'd0, 4'd9,  22'h21F004, 32'h20},       // complete
        {2'd0, 4'd3,  22'h000008, 32'h2},        // equal prio
        {2'd0, 4'd2,  22'h001000, 32'h6},        // pend src1, src2
        {2'd1, 4'd6,  22'h200004, 32'h1},        // R6 tie lowest number
        {2'd1, 4'd6,  22'h200004, 32'h2},        // R6 then src2
        {2'd0, 4'd9,  22'h200004, 32'h1},
        {2'd0, 4'd9,  22'h200004, 32'h2},
        {2'd0, 4'd3,  22'h000004, 32'h0},        // src1 prio zero
        {2'd0, 4'd2,  22'h001000, 32'h2},        // pend src1
        {2'd2, 4'd5,  22'h000000, 32'h0},        // R5 zero prio invisible
        {2'd1, 4'd7,  22'h200004, 32'h0},        // R7 nothing to claim
        {2'd1, 4'd7,  22'h001000, 32'h2},        // R7 src1 still pending
        {2'd1, 4'd3,  22'h000004, 32'h0}         // R3
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] kind, input int req,
                          input logic [21:0] a, input logic [31:0] v);
        @(negedge clk);
        addr = a;
        if (kind == 2'd0) begin
            wdata = v;
            wr    = 1'b1;
        end else if (kind == 2'd1) begin
            rd = 1'b1;
        end
        #1;
        if (kind == 2'd1) check(req, rdata, v, $sformatf("read %h", a));
        if (kind == 2'd2) check(req, 32'(irq), v, "irq lines");
        @(posedge clk);
        #1;
        wr = 1'b0;
        rd = 1'b0;
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        run_op(2'd2, 10, 22'h000000, 32'h0);
        run_op(2'd1, 10, 22'h001000, 32'h0);
        run_op(2'd1, 10, 22'h200004, 32'h0);

        for (int i = 0; i < NV; i++)
            run_op(VEC[i][59:58], int'(VEC[i][57:54]), VEC[i][53:32], VEC[i][31:0]);

        // R10: reset in the middle clears pending, enable and priority
        run_op(2'd0, 10, 22'h000004, 32'h3);
        run_op(2'd2, 10, 22'h000000, 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_op(2'd2, 10, 22'h000000, 32'h0);
        run_op(2'd1, 10, 22'h001000, 32'h0);
        run_op(2'd1, 10, 22'h002000, 32'h0);
        run_op(2'd1, 10, 22'h000004, 32'h0);

        // R1: reserved enable bit stays clear for another hart too
        run_op(2'd0, 1, 22'h002080, 32'hFFFF_FFFF);
        run_op(2'd1, 1, 22'h002080, 32'hFFFF_FFFE);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule